// File: doc/BRIEF.md
# Line-Parity ECC Syndrome Classifier

This block computes a line-parity error-correcting code over a block of data while the block is being read. It then compares that code with the code stored alongside the data and classifies the result. Bytes arrive one per clock. Each byte carries a valid flag, a start flag on the first byte and a last flag on the final byte. A size input chooses between a short block of 256 bytes, whose code halves are 11 bits wide, and a long block of 512 bytes, whose code halves are 12 bits wide.

For every data bit that is set, the code gathers the bit's address into its upper half and the complement of that address into its lower half. At the end of the block the computed code is XORed with the stored code to form a syndrome. The syndrome is reported as one of four outcomes: clean, one correctable data bit (with its location), damage confined to the stored code, or uncorrectable. A single-bit data error is accepted only when the two syndrome halves are exact complements of each other. A syndrome that merely has as many set bits as a half is wide is not enough.

Top module: `lpecc_classifier`

## Requirements
- R1: The code for a block is built as follows. For every set data bit at bit address i = byte_index*8 + bit_position, the upper half is XORed with i and the lower half with the complement of i, limited to the half width. The half width is 12 bits with `size_long`=1 (512 bytes) and 11 bits with `size_long`=0 (256 bytes). `stored_code` carries the upper half in bits [23:12] and the lower half in bits [11:0].
- R2: A syndrome (computed code XOR stored code) of all zeros gives `res_status`=0 (clean).
- R3: When the upper syndrome half XOR the lower half equals all ones in the active width, `res_status`=1 (corrected). The upper syndrome half then gives the failing bit: `res_byte` = half[11:3] and `res_bit` = half[2:0].
- R4: A syndrome whose popcount equals the half width but whose halves are not complements gives `res_status`=3. Examples: data bits 0 and 0x3F flipped in a long block; data bits 0 and 0x3F plus stored lower bit 0 flipped in a short block.
- R5: A syndrome with exactly one set bit gives `res_status`=2 (stored-code error).
- R6: Every other non-zero syndrome gives `res_status`=3 (uncorrectable).
- R7: The result appears at the clock edge that accepts the last byte and is held until the next accepted start. An accepted start without last clears `res_valid` and returns the status to 0.
- R8: Cycles with `in_valid` low are ignored, including their data, start and last inputs.
- R9: With `size_long`=0, `stored_code` bits 11 and 23 have no effect.
- R10: `res_byte` and `res_bit` are zero whenever `res_status` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_long | input | 1 | 1: 512-byte block, 12-bit halves; 0: 256-byte block, 11-bit halves |
| in_valid | input | 1 | Byte qualifier |
| in_start | input | 1 | First byte of a block |
| in_last | input | 1 | Final byte of a block |
| in_data | input | 8 | Data byte |
| stored_code | input | 24 | Stored code {upper, lower}, sampled with the last byte |
| res_valid | output | 1 | Result present |
| res_status | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| res_byte | output | 9 | Byte index of the corrected bit |
| res_bit | output | 3 | Bit position of the corrected bit |

## Verification
The bench builds the block with its default parameters: 12-bit long halves, 11-bit short halves and 8-bit bytes. Both block sizes are exercised through `size_long`. This puts the first and last bit address of each size within reach, along with the unused stored-code bits of the short mode. It also reaches the two weight-matching double-error syndromes that a popcount test would wrongly accept, and lets idle cycles with stray strobes be placed between accepted bytes.

// File: rtl/lpecc_pkg.sv
package lpecc_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'd0,
      ST_FIXED = 2'd1,
      ST_CODE  = 2'd2,
      ST_FATAL = 2'd3
   } ecc_status_e;

endpackage

// File: rtl/lpecc_byte_term.sv
module lpecc_byte_term #(
   parameter int HALF_W = 12,
   parameter int BYTE_W = 8,
   localparam int BIT_W = $clog2(BYTE_W),
   localparam int IDX_W = HALF_W - BIT_W
) (
   input  logic [BYTE_W-1:0] data,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [HALF_W-1:0] mask,
   output logic [HALF_W-1:0] term_hi,
   output logic [HALF_W-1:0] term_lo
);

   logic [HALF_W-1:0] addr_term [BYTE_W];

   for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
      assign addr_term[k] = data[k] ? {byte_idx, BIT_W'(k)} : '0;
   end

   logic [HALF_W-1:0] xor_acc;
   always_comb begin
      xor_acc = '0;
      for (int k = 0; k < BYTE_W; k++) xor_acc ^= addr_term[k];
   end

   // complement of each address folded in: an odd bit count inverts the sum
   assign term_hi = xor_acc & mask;
   assign term_lo = (xor_acc ^ {HALF_W{^data}}) & mask;

endmodule

// File: rtl/lpecc_accum.sv
module lpecc_accum #(
   parameter int HALF_W = 12,
   parameter int BYTE_W = 8,
   localparam int BIT_W = $clog2(BYTE_W),
   localparam int IDX_W = HALF_W - BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic [BYTE_W-1:0] in_data,
   input  logic [HALF_W-1:0] mask,
   output logic [HALF_W-1:0] nxt_hi,
   output logic [HALF_W-1:0] nxt_lo
);

   logic [HALF_W-1:0] acc_hi, acc_lo;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  base_idx;
   logic [HALF_W-1:0] term_hi, term_lo;

   assign base_idx = in_start ? '0 : idx;

   lpecc_byte_term #(.HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_term (
      .data     (in_data),
      .byte_idx (base_idx),
      .mask     (mask),
      .term_hi  (term_hi),
      .term_lo  (term_lo)
   );

   assign nxt_hi = (in_start ? '0 : acc_hi) ^ term_hi;
   assign nxt_lo = (in_start ? '0 : acc_lo) ^ term_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi <= '0;
         acc_lo <= '0;
         idx    <= '0;
      end else if (in_valid) begin
         acc_hi <= nxt_hi;
         acc_lo <= nxt_lo;
         idx    <= base_idx + 1'b1;
      end
   end

endmodule

// File: rtl/lpecc_judge.sv
module lpecc_judge
   import lpecc_pkg::*;
#(
   parameter int HALF_W = 12,
   parameter int BYTE_W = 8,
   localparam int BIT_W = $clog2(BYTE_W),
   localparam int IDX_W = HALF_W - BIT_W,
   localparam int POP_W = $clog2(2 * HALF_W + 1)
) (
   input  logic [HALF_W-1:0] calc_hi,
   input  logic [HALF_W-1:0] calc_lo,
   input  logic [HALF_W-1:0] kept_hi,
   input  logic [HALF_W-1:0] kept_lo,
   input  logic [HALF_W-1:0] mask,
   output ecc_status_e       status,
   output logic [IDX_W-1:0]  fix_byte,
   output logic [BIT_W-1:0]  fix_bit
);

   logic [HALF_W-1:0] syn_hi, syn_lo;
   logic [POP_W-1:0]  weight;

   assign syn_hi = (calc_hi ^ kept_hi) & mask;
   assign syn_lo = (calc_lo ^ kept_lo) & mask;
   assign weight = POP_W'($countones({syn_hi, syn_lo}));

   always_comb begin
      status   = ST_FATAL;
      fix_byte = '0;
      fix_bit  = '0;
      if ({syn_hi, syn_lo} == '0) begin
         status = ST_CLEAN;
      end else if ((syn_hi ^ syn_lo) == mask) begin
         status   = ST_FIXED;
         fix_byte = syn_hi[HALF_W-1:BIT_W];
         fix_bit  = syn_hi[BIT_W-1:0];
      end else if (weight == POP_W'(1)) begin
         status = ST_CODE;
      end
   end

endmodule

// File: rtl/lpecc_classifier.sv
module lpecc_classifier
   import lpecc_pkg::*;
#(
   parameter int LONG_HW  = 12,
   parameter int SHORT_HW = 11,
   parameter int BYTE_W   = 8,
   localparam int BIT_W   = $clog2(BYTE_W),
   localparam int IDX_W   = LONG_HW - BIT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 size_long,
   input  logic                 in_valid,
   input  logic                 in_start,
   input  logic                 in_last,
   input  logic [BYTE_W-1:0]    in_data,
   input  logic [2*LONG_HW-1:0] stored_code,
   output logic                 res_valid,
   output logic [1:0]           res_status,
   output logic [IDX_W-1:0]     res_byte,
   output logic [BIT_W-1:0]     res_bit
);

   if (BYTE_W < 2 || (1 << BIT_W) != BYTE_W) begin : g_bad_byte
      $error("BYTE_W must be a power of two");
   end
   if (SHORT_HW >= LONG_HW || SHORT_HW <= BIT_W) begin : g_bad_half
      $error("SHORT_HW must lie between BIT_W and LONG_HW");
   end

   localparam logic [LONG_HW-1:0] LONG_MASK  = {LONG_HW{1'b1}};
   localparam logic [LONG_HW-1:0] SHORT_MASK = LONG_HW'((1 << SHORT_HW) - 1);

   logic [LONG_HW-1:0] mask;
   assign mask = size_long ? LONG_MASK : SHORT_MASK;

   logic [LONG_HW-1:0] nxt_hi, nxt_lo;

   lpecc_accum #(.HALF_W(LONG_HW), .BYTE_W(BYTE_W)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_start (in_start),
      .in_data  (in_data),
      .mask     (mask),
      .nxt_hi   (nxt_hi),
      .nxt_lo   (nxt_lo)
   );

   ecc_status_e        j_status;
   logic [IDX_W-1:0]   j_byte;
   logic [BIT_W-1:0]   j_bit;

   lpecc_judge #(.HALF_W(LONG_HW), .BYTE_W(BYTE_W)) u_judge (
      .calc_hi  (nxt_hi),
      .calc_lo  (nxt_lo),
      .kept_hi  (stored_code[2*LONG_HW-1:LONG_HW]),
      .kept_lo  (stored_code[LONG_HW-1:0]),
      .mask     (mask),
      .status   (j_status),
      .fix_byte (j_byte),
      .fix_bit  (j_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_status <= ST_CLEAN;
         res_byte   <= '0;
         res_bit    <= '0;
      end else if (in_valid && in_last) begin
         res_valid  <= 1'b1;
         res_status <= j_status;
         res_byte   <= j_byte;
         res_bit    <= j_bit;
      end else if (in_valid && in_start) begin
         res_valid  <= 1'b0;
         res_status <= ST_CLEAN;
         res_byte   <= '0;
         res_bit    <= '0;
      end
   end

endmodule

// File: rtl/lpecc_classifier_chk.sv
module lpecc_classifier_chk #(
   parameter int LONG_HW  = 12,
   parameter int BYTE_W   = 8,
   localparam int BIT_W   = $clog2(BYTE_W),
   localparam int IDX_W   = LONG_HW - BIT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_start,
   input logic             in_last,
   input logic             res_valid,
   input logic [1:0]       res_status,
   input logic [IDX_W-1:0] res_byte,
   input logic [BIT_W-1:0] res_bit
);

   AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last |=> res_valid); // R7
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_start && !in_last |=> !res_valid && res_status == 2'd0); // R7
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !in_valid |=> res_valid && $stable(res_status)
                                 && $stable(res_byte) && $stable(res_bit)); // R7
   AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !res_valid |=> !res_valid); // R8
   AST_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_status != 2'd1 |-> res_byte == '0 && res_bit == '0); // R10
   AST_NO_RESULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> res_status == 2'd0); // R7

endmodule

bind lpecc_classifier lpecc_classifier_chk #(.LONG_HW(LONG_HW), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_start   (in_start),
   .in_last    (in_last),
   .res_valid  (res_valid),
   .res_status (res_status),
   .res_byte   (res_byte),
   .res_bit    (res_bit)
);

// File: tb/lpecc_classifier_test.sv
module lpecc_classifier_test;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        lng;
      logic [7:0]  seed;
      logic        fa;
      logic [11:0] a;
      logic        fb;
      logic [11:0] b;
      logic [23:0] cf;
      logic [1:0]  ex;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 1'b0, 12'h000, 1'b0, 12'h000, 24'h000000, 2'd0}, // R2
      '{1'b1, 8'h37, 1'b0, 12'h000, 1'b0, 12'h000, 24'h000000, 2'd0}, // R2
      '{1'b0, 8'h91, 1'b0, 12'h000, 1'b0, 12'h000, 24'h000000, 2'd0}, // R2
      '{1'b1, 8'h37, 1'b1, 12'h000, 1'b0, 12'h000, 24'h000000, 2'd1}, // R3 first bit
      '{1'b1, 8'h37, 1'b1, 12'hFFF, 1'b0, 12'h000, 24'h000000, 2'd1}, // R3 last bit long
      '{1'b0, 8'h91, 1'b1, 12'h7FF, 1'b0, 12'h000, 24'h000000, 2'd1}, // R3 last bit short
      '{1'b0, 8'h13, 1'b1, 12'h2A5, 1'b0, 12'h000, 24'h000000, 2'd1}, // R3
      '{1'b1, 8'h00, 1'b1, 12'h000, 1'b1, 12'h03F, 24'h000000, 2'd3}, // R4 long
      '{1'b0, 8'h00, 1'b1, 12'h000, 1'b1, 12'h03F, 24'h000001, 2'd3}, // R4 short
      '{1'b1, 8'h37, 1'b0, 12'h000, 1'b0, 12'h000, 24'h020000, 2'd2}, // R5
      '{1'b0, 8'h91, 1'b0, 12'h000, 1'b0, 12'h000, 24'h000020, 2'd2}, // R5
      '{1'b1, 8'h05, 1'b1, 12'h100, 1'b1, 12'h101, 24'h000000, 2'd3}, // R6
      '{1'b1, 8'h37, 1'b1, 12'h123, 1'b0, 12'h000, 24'h000008, 2'd3}, // R6
      '{1'b1, 8'h00, 1'b0, 12'h000, 1'b0, 12'h000, 24'h001001, 2'd3}, // R6
      '{1'b0, 8'h44, 1'b0, 12'h000, 1'b0, 12'h000, 24'h800800, 2'd0}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        size_long = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_start = 1'b0;
   logic        in_last = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic [23:0] stored_code = '0;
   logic        res_valid;
   logic [1:0]  res_status;
   logic [8:0]  res_byte;
   logic [2:0]  res_bit;

   int n_run  = 0;
   int n_fail = 0;
   logic [7:0] mem [512];

   always #(CLK_PERIOD/2) clk = ~clk;

   lpecc_classifier uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .size_long   (size_long),
      .in_valid    (in_valid),
      .in_start    (in_start),
      .in_last     (in_last),
      .in_data     (in_data),
      .stored_code (stored_code),
      .res_valid   (res_valid),
      .res_status  (res_status),
      .res_byte    (res_byte),
      .res_bit     (res_bit)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R1 reference: upper half gathers addresses, lower half their complements
   task automatic ref_code(input int nb, input int hw, output logic [11:0] hi, output logic [11:0] lo);
      int msk = (1 << hw) - 1;
      hi = '0;
      lo = '0;
      for (int i = 0; i < nb * 8; i++) begin
         if (mem[i / 8][i % 8]) begin
            hi ^= 12'(i & msk);
            lo ^= 12'(~i & msk);
         end
      end
   endtask

   task automatic fill(input logic [7:0] seed, input int nb);
      for (int j = 0; j < nb; j++)
         mem[j] = (seed == 0) ? 8'h00 : 8'((j * seed) + (j >> 3));
   endtask

   task automatic send(input int nb, input logic [23:0] code, input logic gaps);
      for (int j = 0; j < nb; j++) begin
         if (gaps) begin
            @(negedge clk);
            in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1; in_data = 8'hFF;
         end
         @(negedge clk);
         if (j == 1)
            chk(!res_valid && res_status == 2'd0, "R7 start clears", {res_valid, res_status}, 0);
         in_valid = 1'b1;
         in_start = (j == 0);
         in_last = (j == nb - 1);
         in_data = mem[j];
         stored_code = code;
      end
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [11:0] hi, lo;
      int nb, hw;
      repeat (3) @(negedge clk);
      chk(!res_valid && res_status == 0 && res_byte == 0 && res_bit == 0,
          "R7 reset state", {res_valid, res_status}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         nb = VEC[v].lng ? 512 : 256;
         hw = VEC[v].lng ? 12 : 11;
         size_long = VEC[v].lng;
         fill(VEC[v].seed, nb);
         ref_code(nb, hw, hi, lo);
         if (VEC[v].fa) mem[VEC[v].a / 8][VEC[v].a % 8] ^= 1'b1;
         if (VEC[v].fb) mem[VEC[v].b / 8][VEC[v].b % 8] ^= 1'b1;
         send(nb, {hi, lo} ^ VEC[v].cf, 1'b0);
         chk(res_valid, "R7 result valid", res_valid, 1);
         chk(res_status == VEC[v].ex, $sformatf("R1-vector %0d status (R2 R3 R4 R5 R6 R9)", v),
             res_status, VEC[v].ex);
         if (VEC[v].ex == 2'd1)
            chk({res_byte, res_bit} == VEC[v].a, $sformatf("R3 location vector %0d", v),
                {res_byte, res_bit}, VEC[v].a);
         else
            chk(res_byte == 0 && res_bit == 0, $sformatf("R10 zero fields vector %0d", v),
                {res_byte, res_bit}, 0);
      end

      // R7: result held across idle cycles
      repeat (5) @(negedge clk);
      chk(res_valid && res_status == 2'd0, "R7 hold", {res_valid, res_status}, 4);

      // R8: idle cycles carrying stray data and strobes are ignored
      size_long = 1'b0;
      fill(8'h44, 256);
      ref_code(256, 11, hi, lo);
      mem[12'h155 / 8][12'h155 % 8] ^= 1'b1;
      send(256, {hi, lo}, 1'b1);
      chk(res_valid && res_status == 2'd1, "R8 gapped status", res_status, 1);
      chk({res_byte, res_bit} == 12'h155, "R8 gapped location", {res_byte, res_bit}, 12'h155);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule